// File: doc/BRIEF.md
# Double-Buffered Polyphase Coefficient Store

This block holds the kernel coefficients that a polyphase filter datapath uses. The storage is split into rows: one row carries every coefficient needed for a single output phase, or for one processing cycle of a multi-cycle decimator. The number of rows is the product of the horizontal phase count, the vertical phase count and the minimum input interval. Software or a loader writes single coefficients through a write-only port. The address is the row index placed above the column index.

There are two banks. One is active and feeds the datapath. The other is standby and takes every write. A swap request raises a pending flag. The exchange of the two roles waits for the next frame-start marker, so the kernel in use never changes partway through a frame. The flag stays high until the exchange happens.

The datapath asks for a row by index and receives the whole row one cycle later. Each coefficient is widened to the output lane width by sign or zero extension, chosen by a parameter.

Top module: `coef_dbuf_store`

## Requirements
- R1: After a synchronous active-low reset, `swap_pending` is low and every coefficient of both banks reads as zero.
- R2: A write applies `wr_data` to the coefficient addressed by `wr_addr`. The row index sits in the upper `ROW_AW` bits and the column index in the lower `COL_AW` bits.
- R3: Writes change only the standby bank. Reads from the active bank are unchanged by any write.
- R4: `swap_req` while `swap_pending` is low makes `swap_pending` high in the next cycle.
- R5: The bank exchange happens on the first clock edge where `frame_start` is high while `swap_pending` is high. `swap_pending` is low in the following cycle, and a read sampled on that same edge already returns the new active bank.
- R6: `swap_req` while `swap_pending` is already high is absorbed. Only one exchange results, and a later `frame_start` does not exchange the banks back.
- R7: `frame_start` while `swap_pending` is low changes neither the banks nor `swap_pending`.
- R8: `rd_coefs` presents the row whose index was on `rd_row` at the previous clock edge. Column c occupies bits [c*OW +: OW].
- R9: Each lane is the stored CW-bit coefficient extended to OW bits. The extension copies the coefficient's top bit when `SIGNED_COEF` is 1 and fills with zeros when it is 0.
- R10: The row count equals PHASE_X*PHASE_Y*REPEAT (9 by default). A write whose row index is at or above it is ignored, and a read of such a row returns all zeros.
- R11: After an exchange, the previously active bank becomes standby. Later writes go to it and are seen only after the next exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Coefficient write strobe |
| wr_addr | input | ROW_AW+COL_AW | Write address: row index above column index |
| wr_data | input | CW | Coefficient value to store |
| swap_req | input | 1 | Request to exchange active and standby banks |
| frame_start | input | 1 | Marks the first pixel of a frame; the exchange point |
| swap_pending | output | 1 | High from the cycle after a request until the exchange |
| rd_row | input | ROW_AW | Row index requested by the datapath |
| rd_coefs | output | COLS*OW | Extended coefficients of the requested row, column 0 in the low lane |

## Verification
The assertions check every cycle that the pending flag sets, holds, clears and ignores repeated requests in line with R4 to R7. They also check that lanes carry a correct sign or zero extension and that an out-of-range row reads as zero. What only the bench scenarios can show is which bank a read comes from. That covers whether a write leaked into the active kernel, whether the exchange landed on the frame-start edge with the new bank visible in that same read, and whether later writes reach the bank that has just been retired. The bench finds these by comparing every returned row with a two-bank model it keeps itself, under directed sequences and seeded random traffic.

// File: rtl/coef_dbuf_pkg.sv
// Package: shared helpers for the double-buffered coefficient store.
// Assumes: phase counts and repeat factor are at least 1.
package coef_dbuf_pkg;

    // Which of the two physical banks plays a role.
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_t;

    // Row count: one row per phase per processing cycle.
    function automatic int phase_rows(input int px, input int py, input int rep);
        return px * py * rep;
    endfunction

    // Index width that is never zero.
    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/coef_addr_split.sv
// Module: splits the concatenated write address into row and column and
// range-checks both the write target and the read row.
// Assumes: row index is the upper field of the write address.
module coef_addr_split #(
    parameter int ROWS   = 9,
    parameter int COLS   = 4,
    parameter int ROW_AW = 4,
    parameter int COL_AW = 2
) (
    input  logic                     wr_en,
    input  logic [ROW_AW+COL_AW-1:0] wr_addr,
    input  logic [ROW_AW-1:0]        rd_row,
    output logic                     wr_hit,
    output logic [ROW_AW-1:0]        wr_row,
    output logic [COL_AW-1:0]        wr_col,
    output logic                     rd_hit
);

    localparam logic [ROW_AW:0] ROW_LIM = (ROW_AW+1)'(ROWS);
    localparam logic [COL_AW:0] COL_LIM = (COL_AW+1)'(COLS);

    // Field split of the write address.
    assign wr_row = wr_addr[ROW_AW+COL_AW-1:COL_AW];
    assign wr_col = wr_addr[COL_AW-1:0];

    // Range qualification of both sides.
    always_comb begin
        wr_hit = wr_en && ({1'b0, wr_row} < ROW_LIM) && ({1'b0, wr_col} < COL_LIM);
        rd_hit = ({1'b0, rd_row} < ROW_LIM);
    end

endmodule

// File: rtl/coef_bank_ctrl.sv
// Module: tracks the pending swap and which bank is active. The exchange
// waits for a frame-start marker seen while a request is pending.
// Assumes: frame_start is a single-cycle marker synchronous to clk.
module coef_bank_ctrl
    import coef_dbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  swap_req,
    input  logic  frame_start,
    output logic  pending,
    output bank_t act_next
);

    bank_t act_q;

    // Active bank after this edge: flips only on a pending swap at frame start.
    always_comb begin
        act_next = act_q;
        if (pending && frame_start) begin
            act_next = (act_q == BANK_A) ? BANK_B : BANK_A;
        end
    end

    // Role and request state; requests while pending are absorbed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= BANK_A;
            pending <= 1'b0;
        end else begin
            act_q <= act_next;
            if (pending) begin
                pending <= !frame_start;
            end else begin
                pending <= swap_req;
            end
        end
    end

endmodule

// File: rtl/coef_bank_array.sv
// Module: two banks of ROWS x COLS coefficients, one write port and a
// registered full-row read with per-lane sign or zero extension.
// Assumes: wr_bank never equals rd_bank in the same cycle (standby vs active).
module coef_bank_array #(
    parameter int ROWS        = 9,
    parameter int COLS        = 4,
    parameter int CW          = 8,
    parameter int OW          = 12,
    parameter bit SIGNED_COEF = 1'b1,
    parameter int ROW_AW      = 4,
    parameter int COL_AW      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic                 wr_bank,
    input  logic [ROW_AW-1:0]    wr_row,
    input  logic [COL_AW-1:0]    wr_col,
    input  logic [CW-1:0]        wr_data,
    input  logic                 rd_hit,
    input  logic                 rd_bank,
    input  logic [ROW_AW-1:0]    rd_row,
    output logic [COLS*OW-1:0]   rd_coefs
);

    localparam int EXT = OW - CW;

    logic [CW-1:0]      mem [2][ROWS][COLS];
    logic [ROW_AW-1:0]  rd_idx;
    logic [COLS*OW-1:0] row_wide;

    // Guard the read index so an out-of-range row never indexes the array.
    assign rd_idx = rd_hit ? rd_row : '0;

    // Storage: cleared by reset, then one coefficient written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int c = 0; c < COLS; c++) begin
                        mem[b][r][c] <= '0;
                    end
                end
            end
        end else if (wr_hit) begin
            mem[wr_bank][wr_row][wr_col] <= wr_data;
        end
    end

    // Per-lane widening, variant picked by parameters.
    for (genvar c = 0; c < COLS; c++) begin : g_lane
        logic [CW-1:0] raw;
        assign raw = mem[rd_bank][rd_idx][c];
        if (EXT == 0) begin : g_plain
            assign row_wide[c*OW +: OW] = raw;
        end else if (SIGNED_COEF) begin : g_sext
            assign row_wide[c*OW +: OW] = {{EXT{raw[CW-1]}}, raw};
        end else begin : g_zext
            assign row_wide[c*OW +: OW] = {{EXT{1'b0}}, raw};
        end
    end

    // Registered row output; out-of-range rows read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_coefs <= '0;
        end else begin
            rd_coefs <= rd_hit ? row_wide : '0;
        end
    end

endmodule

// File: rtl/coef_dbuf_store.sv
// Module: top of the double-buffered coefficient store. Writes land in the
// standby bank; a requested exchange takes effect at the next frame start.
// Assumes: OW >= CW; row index is the upper field of wr_addr.
module coef_dbuf_store
    import coef_dbuf_pkg::*;
#(
    parameter int PHASE_X     = 3,
    parameter int PHASE_Y     = 3,
    parameter int REPEAT      = 1,
    parameter int COLS        = 4,
    parameter int CW          = 8,
    parameter int OW          = 12,
    parameter bit SIGNED_COEF = 1'b1,
    localparam int ROWS       = phase_rows(PHASE_X, PHASE_Y, REPEAT),
    localparam int ROW_AW     = idx_bits(ROWS),
    localparam int COL_AW     = idx_bits(COLS),
    localparam int AW         = ROW_AW + COL_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CW-1:0]      wr_data,
    input  logic               swap_req,
    input  logic               frame_start,
    output logic               swap_pending,
    input  logic [ROW_AW-1:0]  rd_row,
    output logic [COLS*OW-1:0] rd_coefs
);

    logic              wr_hit;
    logic              rd_hit;
    logic [ROW_AW-1:0] wr_row;
    logic [COL_AW-1:0] wr_col;
    bank_t             act_next;
    logic              rd_bank;
    logic              wr_bank;

    // Read follows the post-edge active bank; writes go to its partner.
    assign rd_bank = act_next;
    assign wr_bank = ~rd_bank;

    coef_addr_split #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .ROW_AW(ROW_AW),
        .COL_AW(COL_AW)
    ) u_split (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .rd_row (rd_row),
        .wr_hit (wr_hit),
        .wr_row (wr_row),
        .wr_col (wr_col),
        .rd_hit (rd_hit)
    );

    coef_bank_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_req   (swap_req),
        .frame_start(frame_start),
        .pending    (swap_pending),
        .act_next   (act_next)
    );

    coef_bank_array #(
        .ROWS       (ROWS),
        .COLS       (COLS),
        .CW         (CW),
        .OW         (OW),
        .SIGNED_COEF(SIGNED_COEF),
        .ROW_AW     (ROW_AW),
        .COL_AW     (COL_AW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_bank (wr_bank),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (wr_data),
        .rd_hit  (rd_hit),
        .rd_bank (rd_bank),
        .rd_row  (rd_row),
        .rd_coefs(rd_coefs)
    );

endmodule

// File: rtl/coef_dbuf_store_chk.sv
// Module: property checker for the coefficient store, bound to the top.
// Assumes: only top-level ports are observed.
module coef_dbuf_store_chk #(
    parameter int ROWS        = 9,
    parameter int COLS        = 4,
    parameter int CW          = 8,
    parameter int OW          = 12,
    parameter bit SIGNED_COEF = 1'b1,
    parameter int ROW_AW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               swap_req,
    input logic               frame_start,
    input logic               swap_pending,
    input logic [ROW_AW-1:0]  rd_row,
    input logic [COLS*OW-1:0] rd_coefs
);

    localparam int EXT = OW - CW;

    // A fresh request raises the flag next cycle.
    assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_pending && swap_req) |=> swap_pending);

    // A frame start while pending performs the exchange and drops the flag.
    assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pending && frame_start) |=> !swap_pending);

    // Without a frame start the flag holds, whatever swap_req does.
    assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pending && !frame_start) |=> swap_pending);

    // Idle: no request, no flag, regardless of frame starts.
    assert_pend_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_pending && !swap_req) |=> !swap_pending);

    // Rows past the last one return zeros.
    assert_row_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_row) >= ROWS) |=> (rd_coefs == '0));

    // Lane upper bits follow the chosen extension rule.
    if (EXT > 0) begin : g_ext
        for (genvar c = 0; c < COLS; c++) begin : g_lane
            if (SIGNED_COEF) begin : g_s
                assert_lane_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    rd_coefs[c*OW+CW +: EXT] == {EXT{rd_coefs[c*OW+CW-1]}});
            end else begin : g_u
                assert_lane_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    rd_coefs[c*OW+CW +: EXT] == '0);
            end
        end
    end

endmodule

bind coef_dbuf_store coef_dbuf_store_chk #(
    .ROWS       (ROWS),
    .COLS       (COLS),
    .CW         (CW),
    .OW         (OW),
    .SIGNED_COEF(SIGNED_COEF),
    .ROW_AW     (ROW_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .swap_req    (swap_req),
    .frame_start (frame_start),
    .swap_pending(swap_pending),
    .rd_row      (rd_row),
    .rd_coefs    (rd_coefs)
);

// File: tb/sim_coef_dbuf_store.sv
// Bench: directed scenarios plus seeded random traffic, checked every cycle
// against an independent two-bank model kept in the bench.
module sim_coef_dbuf_store;

    localparam int ROWS   = 9;   // 3 x 3 phases x 1
    localparam int COLS   = 4;
    localparam int CW     = 8;
    localparam int OW     = 12;
    localparam int ROW_AW = 4;
    localparam int COL_AW = 2;
    localparam int AW     = ROW_AW + COL_AW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [AW-1:0]      wr_addr = '0;
    logic [CW-1:0]      wr_data = '0;
    logic               swap_req = 1'b0;
    logic               frame_start = 1'b0;
    logic               swap_pending;
    logic [ROW_AW-1:0]  rd_row = '0;
    logic [COLS*OW-1:0] rd_coefs;

    int vectors = 0;
    int fails   = 0;

    logic [CW-1:0]      mdl [2][ROWS][COLS];
    int                 msel;
    logic               mpend;
    logic [COLS*OW-1:0] exp_rd;

    coef_dbuf_store #(
        .PHASE_X(3), .PHASE_Y(3), .REPEAT(1),
        .COLS(COLS), .CW(CW), .OW(OW), .SIGNED_COEF(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .swap_req(swap_req), .frame_start(frame_start),
        .swap_pending(swap_pending), .rd_row(rd_row), .rd_coefs(rd_coefs)
    );

    always #2 clk = ~clk;

    // Signed widening of one coefficient.
    function automatic logic [OW-1:0] widen(input logic [CW-1:0] v);
        return {{(OW-CW){v[CW-1]}}, v};
    endfunction

    // Expected row from a model bank.
    function automatic logic [COLS*OW-1:0] model_row(input int b, input int r);
        logic [COLS*OW-1:0] acc = '0;
        if (r < ROWS) begin
            for (int c = 0; c < COLS; c++) acc[c*OW +: OW] = widen(mdl[b][r][c]);
        end
        return acc;
    endfunction

    task automatic check_bits(input string tag, input string what,
                              input logic [COLS*OW-1:0] act, input logic [COLS*OW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, compare at next negedge.
    task automatic tick(input logic we, input int row, input int col, input logic [CW-1:0] d,
                        input logic sw, input logic fs, input int rrow, input string tag);
        int sel_n;
        wr_en       = we;
        wr_addr     = {row[ROW_AW-1:0], col[COL_AW-1:0]};
        wr_data     = d;
        swap_req    = sw;
        frame_start = fs;
        rd_row      = rrow[ROW_AW-1:0];
        @(posedge clk);
        sel_n = (mpend && fs) ? 1 - msel : msel;
        if (we && row < ROWS && col < COLS) mdl[1 - sel_n][row][col] = d;
        exp_rd = model_row(sel_n, rrow);
        mpend  = mpend ? !fs : sw;
        msel   = sel_n;
        @(negedge clk);
        check_bits(tag, "rd_coefs", rd_coefs, exp_rd);
        check_bits(tag, "swap_pending", {{(COLS*OW-1){1'b0}}, swap_pending},
                   {{(COLS*OW-1){1'b0}}, mpend});
    endtask

    task automatic rd(input int r, input string tag);
        tick(1'b0, 0, 0, '0, 1'b0, 1'b0, r, tag);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        msel  = 0;
        mpend = 1'b0;
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) mdl[b][r][c] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs and of every row in the active bank.
        check_bits("R1", "pending after reset", {{(COLS*OW-1){1'b0}}, swap_pending}, '0);
        check_bits("R1", "rd_coefs after reset", rd_coefs, '0);
        for (int r = 0; r < ROWS; r++) rd(r, "R1");

        // R2/R3: writes into standby are invisible to the active bank.
        tick(1'b1, 2, 1, 8'h85, 1'b0, 1'b0, 2, "R3");
        tick(1'b1, 8, 3, 8'h7F, 1'b0, 1'b0, 2, "R2");
        tick(1'b1, 0, 0, 8'h01, 1'b0, 1'b0, 8, "R3");
        rd(2, "R3");
        // R7: frame start without a request does nothing.
        tick(1'b0, 0, 0, '0, 1'b0, 1'b1, 2, "R7");
        // R4: request raises pending.
        tick(1'b0, 0, 0, '0, 1'b1, 1'b0, 2, "R4");
        // R6: repeated request while pending is absorbed.
        tick(1'b0, 0, 0, '0, 1'b1, 1'b0, 2, "R6");
        rd(2, "R6");
        // R5: exchange on frame start; same-edge read sees new bank (R9 sign ext).
        tick(1'b0, 0, 0, '0, 1'b0, 1'b1, 2, "R5");
        rd(8, "R2");
        rd(0, "R8");
        // R6: a later frame start must not swap back.
        tick(1'b0, 0, 0, '0, 1'b0, 1'b1, 2, "R6");
        rd(2, "R9");
        // R11: writes now reach the retired bank, shown after the next exchange.
        tick(1'b1, 2, 1, 8'h11, 1'b0, 1'b0, 2, "R11");
        tick(1'b0, 0, 0, '0, 1'b1, 1'b0, 2, "R11");
        tick(1'b0, 0, 0, '0, 1'b0, 1'b1, 2, "R11");
        rd(8, "R11");
        // R10: writes to rows past the end are ignored; such reads give zero.
        tick(1'b1, 9, 0, 8'hAA, 1'b0, 1'b0, 9, "R10");
        tick(1'b1, 15, 2, 8'h55, 1'b0, 1'b0, 15, "R10");
        tick(1'b0, 0, 0, '0, 1'b1, 1'b0, 9, "R10");
        tick(1'b0, 0, 0, '0, 1'b0, 1'b1, 0, "R10");
        for (int r = 0; r < 16; r++) rd(r, "R10");
        // R4/R5: request and frame start in the same cycle: no exchange yet.
        tick(1'b0, 0, 0, '0, 1'b1, 1'b1, 2, "R4");
        tick(1'b0, 0, 0, '0, 1'b0, 1'b1, 2, "R5");

        // R8: seeded random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            tick(($urandom % 3) != 0, int'($urandom % 16), int'($urandom % 4),
                 CW'($urandom), ($urandom % 16) == 0, ($urandom % 24) == 0,
                 int'($urandom % 16), "R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule